// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked request interface and an external asynchronous static RAM with active-low chip, output and write enables and a shared tri-state data bus. Each accepted request becomes one strobe sequence on the memory pins, with every phase lasting a whole number of clock cycles. The phase lengths are worked out at elaboration time from the clock period and the RAM's minimum timing figures, all given as parameters in nanoseconds.

A write runs in three phases. First comes one setup cycle with chip-enable low, write-enable high and the controller driving address and data. Then write-enable stays low for the pulse count. Last comes one hold cycle with write-enable high again, after which the bus is released. A read keeps chip-enable and output-enable low for the access count. The data bus is sampled on the last cycle of that count and the result goes to the user side. Output-enable stays high for the whole of a write, and every read is followed by a recovery gap in which all strobes are high. This keeps the two ends from ever driving the bus at the same time. Chip-enable stays high between requests so that the RAM can drop into standby.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it, mem_ce_n_o, mem_oe_n_o and mem_we_n_o are 1, mem_dq_oe_o is 0, done_o is 0 and ready_o is 1.
- R2: Whenever ready_o is 1, mem_ce_n_o is 1, so the RAM is deselected between requests.
- R3: A write holds chip-enable low for WP+2 cycles. write-enable is high in the first and last of them and low for exactly WP cycles between, where WP is the largest of ceil(t_wp/T), ceil(t_sd/T)-1, ceil(t_sce/T)-1 and ceil(t_wc/T)-2, and never less than 1.
- R4: mem_oe_n_o stays 1 for the whole of a write, and mem_dq_oe_o is 1 in every cycle of a write and only when mem_oe_n_o is 1.
- R5: mem_addr_o and mem_dq_o equal the request's address and data in every cycle of a write, and do not change from a cycle with write-enable low to the next.
- R6: A read holds chip-enable and output-enable low with write-enable high for exactly RD cycles, RD = max(ceil(t_aa/T), ceil(t_rc/T), ceil(t_doe/T)). rdata_o takes the bus value present on the last of those cycles.
- R7: done_o is a one-cycle pulse. It is high 2+WP+1 cycles after a write is accepted, or RD+1 cycles after a read is accepted (counting the accepting edge as cycle 0 and sampling between edges). On a read, rdata_o is valid while done_o is high.
- R8: After a read, all strobes stay high and ready_o stays low for TURN = ceil(t_hzoe/T) cycles after done_o. The controller never drives the bus in a cycle in which the RAM may still be driving it.
- R9: A request is taken only in a cycle with ready_o at 1. A req_i pulse while busy starts no memory cycle and changes no stored word.
- R10: The chip-enable-low span of a write is at least ceil(t_wc/T) cycles, and that of a read at least ceil(t_rc/T) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_addr_o | output | ADDR_W | RAM address bus |
| mem_ce_n_o | output | 1 | RAM chip enable, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_dq_o | output | DATA_W | Data toward the RAM |
| mem_dq_i | input | DATA_W | Data from the RAM |
| mem_dq_oe_o | output | 1 | Enable for the controller's bus drivers |

## Verification
The bench builds the controller with ADDR_W = 5 and a 5 ns clock, and keeps the default nanosecond figures. That gives a 9-cycle write pulse, an 11-cycle read access and a 4-cycle read recovery. The small address space allows every word to be written and read back, followed by read-then-write pairs and reads with a stray request injected while busy. The RAM model in the bench returns the wrong data until the full access count has elapsed, and it keeps driving the bus for the float time after a read. As a result, a sample taken too early, a recovery gap that is too short, or drivers enabled too soon all show up at the ports.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } seq_state_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, floored at one cycle
  function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WP_CYC    = 9,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned RD_CYC    = 11,
  parameter int unsigned TURN_CYC  = 4,
  parameter int          CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] LEN_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_WP    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_RD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_TURN  = CNT_W'(TURN_CYC - 1);

  seq_state_e state_q, state_d;
  logic       fin_d;
  logic       done_q;
  logic       ce_n_q, oe_n_q, we_n_q, dq_oe_q;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    len_o     = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    fin_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          load_o   = 1'b1;
          if (we_i) begin
            state_d = ST_WSETUP;
            len_o   = LEN_SETUP;
          end else begin
            state_d = ST_RACC;
            len_o   = LEN_RD;
          end
        end
      end
      ST_WSETUP: begin
        if (zero_i) begin
          state_d = ST_WPULSE;
          load_o  = 1'b1;
          len_o   = LEN_WP;
        end
      end
      ST_WPULSE: begin
        if (zero_i) begin
          state_d = ST_WHOLD;
          load_o  = 1'b1;
          len_o   = LEN_HOLD;
        end
      end
      ST_WHOLD: begin
        if (zero_i) begin
          state_d = ST_IDLE;
          fin_d   = 1'b1;
        end
      end
      ST_RACC: begin
        if (zero_i) begin
          state_d   = ST_RTURN;
          load_o    = 1'b1;
          len_o     = LEN_TURN;
          capture_o = 1'b1;
          fin_d     = 1'b1;
        end
      end
      ST_RTURN: begin
        if (zero_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_d;
      ce_n_q  <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
      oe_n_q  <= (state_d != ST_RACC);
      we_n_q  <= (state_d != ST_WPULSE);
      dq_oe_q <= (state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign dq_oe_o = dq_oe_q;

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address and data held until the next accept: covers zero hold time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int          ADDR_W     = 19,
  parameter int          DATA_W     = 8,
  parameter int unsigned CLK_NS     = 5,
  parameter int unsigned T_WC_NS    = 55,
  parameter int unsigned T_WP_NS    = 45,
  parameter int unsigned T_SCE_NS   = 45,
  parameter int unsigned T_SD_NS    = 30,
  parameter int unsigned T_RC_NS    = 55,
  parameter int unsigned T_AA_NS    = 55,
  parameter int unsigned T_DOE_NS   = 25,
  parameter int unsigned T_HZOE_NS  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int unsigned SETUP_CYC = 1;
  localparam int unsigned HOLD_CYC  = 1;
  localparam int unsigned WP_CYC    = umax(
      umax(ns_to_cyc(T_WP_NS, CLK_NS), sat_sub(ns_to_cyc(T_SD_NS, CLK_NS), SETUP_CYC)),
      umax(sat_sub(ns_to_cyc(T_SCE_NS, CLK_NS), SETUP_CYC),
           sat_sub(ns_to_cyc(T_WC_NS, CLK_NS), SETUP_CYC + HOLD_CYC)));
  localparam int unsigned RD_CYC    = umax(
      umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)),
      ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned TURN_CYC  = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned MAX_LEN   = umax(umax(WP_CYC, RD_CYC), TURN_CYC);
  localparam int          CNT_W     = $clog2(MAX_LEN + 1);

  logic             load;
  logic [CNT_W-1:0] len;
  logic             zero;
  logic             accept;
  logic             capture;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .zero_o (zero)
  );

  sram_seq_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .WP_CYC    (WP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RD_CYC    (RD_CYC),
    .TURN_CYC  (TURN_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .zero_i    (zero),
    .load_o    (load),
    .len_o     (len),
    .accept_o  (accept),
    .capture_o (capture),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .ce_n_o    (mem_ce_n_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .dq_oe_o   (mem_dq_oe_o)
  );

  sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              mem_ce_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic [ADDR_W-1:0] mem_addr_o
);

  a_r2_standby_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_n_o);

  a_r3_setup_before_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> $past(!mem_ce_n_o));

  a_r4_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && !mem_ce_n_o && mem_dq_oe_o));

  a_r4_drive_only_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  a_r5_stable_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |=> ($stable(mem_dq_o) && $stable(mem_addr_o)));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_recover_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (!ready_o && mem_ce_n_o && !mem_dq_oe_o));

  a_r9_accept_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> $past(ready_o && req_i));

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_dq_o    (mem_dq_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;

  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int WORDS = 1 << AW;
  localparam int CLK   = 5;
  // expected phase lengths, ceil(ns/CLK)
  localparam int WP    = 9;   // max(45/5, 30/5-1, 45/5-1, 55/5-2)
  localparam int RD    = 11;  // max(55/5, 55/5, 25/5)
  localparam int TURN  = 4;   // 20/5
  localparam int WC_C  = 11;
  localparam int RC_C  = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK/2.0) clk = ~clk;

  sram_strobe_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK)) u_sram_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .mem_addr_o(mem_addr),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(dq_o),
    .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // RAM model
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] shadow [WORDS];
  logic          read_act;
  int            rd_age = 0;
  int            tail = 0;
  int            clash = 0;
  int            ce_falls = 0;
  logic          prev_wlo = 1'b0;
  logic          prev_ce_n = 1'b1;

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  assign read_act = !ce_n && !oe_n && we_n;
  assign dq_i = (read_act && rd_age >= RD - 1) ? mem[mem_addr] : ~mem[mem_addr];

  always @(posedge clk) begin
    if (read_act) rd_age <= rd_age + 1; else rd_age <= 0;
    if (read_act) tail <= TURN; else if (tail > 0) tail <= tail - 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_val(i);
      prev_wlo <= 1'b0;
      prev_ce_n <= 1'b1;
    end else begin
      if (prev_wlo && we_n && !ce_n) mem[mem_addr] <= dq_o;
      prev_wlo <= !we_n && !ce_n;
      if (prev_ce_n && !ce_n) ce_falls <= ce_falls + 1;
      prev_ce_n <= ce_n;
      if (dq_oe && (read_act || tail != 0)) clash <= clash + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int cyc, ce_lo, we_lo, oe_lo, bad_drv, bad_dat, first_we, last_we, turn, bad_turn, falls0;
    while (!ready) @(negedge clk);
    chk(ce_n == 1'b1, "R2 ce_n high while ready", ce_n, 1);
    falls0 = ce_falls;
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    cyc = 1; ce_lo = 0; we_lo = 0; oe_lo = 0; bad_drv = 0; bad_dat = 0;
    first_we = -1; last_we = -1;
    while (!done && cyc < 300) begin
      if (!ce_n) begin
        ce_lo++;
        if (first_we < 0) first_we = we_n;
        last_we = we_n;
        if (!we_n) we_lo++;
        if (!oe_n) oe_lo++;
        if (dq_oe != w) bad_drv++;
        if (mem_addr != a || (w && dq_o != d)) bad_dat++;
      end
      if (poke && cyc == 3) begin
        req = 1'b1; we = 1'b1; addr = a ^ 1; wdata = 8'hEE;
      end else req = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req = 1'b0;
    if (w) begin
      chk(cyc == WP + 3, "R7 write done latency", cyc, WP + 3);
      chk(ce_lo == WP + 2, "R3 write ce low span", ce_lo, WP + 2);
      chk(we_lo == WP, "R3 write pulse length", we_lo, WP);
      chk(first_we == 1 && last_we == 1, "R3 setup/hold we high", {first_we[0], last_we[0]}, 3);
      chk(oe_lo == 0 && bad_drv == 0, "R4 oe high and driving in write", oe_lo + bad_drv, 0);
      chk(bad_dat == 0, "R5 addr/data held in write", bad_dat, 0);
      chk(ce_lo >= WC_C, "R10 write cycle time", ce_lo, WC_C);
      chk(ready == 1'b1, "R7 ready with write done", ready, 1);
      shadow[a] = d;
    end else begin
      chk(cyc == RD + 1, "R7 read done latency", cyc, RD + 1);
      chk(ce_lo == RD && oe_lo == RD && we_lo == 0, "R6 read strobe span", ce_lo, RD);
      chk(bad_drv == 0 && bad_dat == 0, "R6 no drive, addr held in read", bad_drv + bad_dat, 0);
      chk(rdata == shadow[a], "R6 read data", rdata, shadow[a]);
      chk(ce_lo >= RC_C, "R10 read cycle time", ce_lo, RC_C);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single pulse", done, 0);
      turn = 1; bad_turn = 0;
      while (!ready && turn < 50) begin
        if (!ce_n || !oe_n || !we_n || dq_oe) bad_turn++;
        @(negedge clk);
        turn++;
      end
      chk(turn == TURN && bad_turn == 0, "R8 read recovery gap", turn, TURN);
    end
    if (poke) chk(ce_falls == falls0 + 1, "R9 busy request ignored", ce_falls - falls0, 1);
  endtask

  initial begin
    #(CLK * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) shadow[i] = init_val(i);
    repeat (3) @(negedge clk);
    chk({ce_n, oe_n, we_n, dq_oe, done, ready} == 6'b111001, "R1 outputs in reset",
        {ce_n, oe_n, we_n, dq_oe, done, ready}, 6'b111001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ce_n, oe_n, we_n, dq_oe, done, ready} == 6'b111001, "R1 outputs after reset",
        {ce_n, oe_n, we_n, dq_oe, done, ready}, 6'b111001);
    // full write sweep then full read sweep
    for (int i = 0; i < WORDS; i++) run_op(1'b1, AW'(i), DW'((i * 73 + 5) & 8'hFF), 1'b0);
    for (int i = 0; i < WORDS; i++) run_op(1'b0, AW'(i), '0, 1'b0);
    // read immediately followed by write, then read back
    for (int i = 0; i < 8; i++) begin
      run_op(1'b0, AW'(i * 3), '0, 1'b0);
      run_op(1'b1, AW'(i * 3), DW'(8'h5A ^ i), 1'b0);
      run_op(1'b0, AW'(i * 3), '0, 1'b0);
    end
    // stray request while a read is in flight
    for (int i = 0; i < 4; i++) begin
      run_op(1'b0, AW'(i * 8), '0, 1'b1);
      repeat (3) begin
        @(negedge clk);
        chk(ce_n == 1'b1, "R2 deselected when idle", ce_n, 1);
      end
      run_op(1'b0, AW'((i * 8) ^ 1), '0, 1'b0);
    end
    chk(clash == 0, "R8 no bus contention", clash, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule